// File: doc/BRIEF.md
# Microsecond One-Shot / Periodic Down-Timer

This block counts down on an externally supplied one-microsecond tick and raises a level interrupt when the count runs out. Software programs it with one 32-bit arming word. That word carries an enable bit, a periodic-mode bit and a load value. To get an expiry after N ticks, software loads N-1. A request of one tick or fewer loads zero. In one-shot mode the timer stops itself after it expires. In periodic mode it reloads the programmed value and keeps running. Writing an all-zero word disarms the timer.

A second register reports the pending-interrupt flag and the remaining count. Writing a one to the flag position of that register acknowledges the interrupt. The tick is a one-cycle strobe in the block's clock domain. A parameter can instead treat it as a level and count its rising edges. Reads return data one cycle after the request, marked by a valid strobe.

Top module: `usec_timer`

## Requirements
- R1: After reset the timer is disarmed, `irq` is low, and both registers read 0.
- R2: Arming word (select 0) layout: bit 31 enables, bit 30 selects periodic mode, bits 28:0 hold the load value. Reading select 0 returns enable, periodic and load value in those positions. Bit 29 always reads 0.
- R3: While enabled, each tick decrements the count. With load value L, the expiry happens on the (L+1)-th tick after the write. Ticks while disabled leave the count unchanged.
- R4: One-shot expiry sets the interrupt flag and clears the enable bit. The count stays at 0 and no further expiry occurs until the timer is rewritten.
- R5: Periodic expiry reloads the load value and keeps counting, so it expires every L+1 ticks.
- R6: Writing 0 to select 0 disarms the timer. The count reads 0 and later ticks raise no interrupt.
- R7: Any write to select 0 loads the count from the written value at once. It takes priority over a tick in the same cycle.
- R8: `irq` is active-high and stays high until a write to select 1 with bit 30 set. A select-1 write with bit 30 clear leaves `irq` unchanged.
- R9: If an acknowledge and an expiry occur in the same cycle, `irq` stays high.
- R10: Reading select 1 returns the interrupt flag in bit 30 and the remaining count in bits 28:0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | Microsecond tick strobe (or level when edge mode is chosen) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_sel | input | 1 | Register select: 0 arming word, 1 status/acknowledge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with `reg_rvalid` |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| irq | output | 1 | Level-high expiry interrupt |

## Verification
Two pairs of events can land in the same clock cycle. The first is an expiring tick together with an acknowledge write. The second is a tick together with a rewrite of the arming word. The bench drives both strobes on the same falling edge, so the design samples them at one rising edge. For the first pair it expects `irq` to stay high. For the second it expects the status read to show the freshly written value, not a decremented one.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
   localparam int unsigned WORD_W = 32;
   typedef enum logic {
      SEL_ARM  = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/usec_tick_cond.sv
module usec_tick_cond #(
   parameter bit EDGE_MODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_out
);
   if (EDGE_MODE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= tick_in;
      end
      assign tick_out = tick_in & ~prev_q;
   end else begin : g_pulse
      assign tick_out = tick_in;
   end
endmodule

// File: rtl/usec_arm_reg.sv
module usec_arm_reg #(
   parameter int unsigned CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_arm,
   input  logic             wr_en_bit,
   input  logic             wr_per_bit,
   input  logic [CNT_W-1:0] wr_load,
   input  logic             self_stop,
   output logic             en,
   output logic             per,
   output logic [CNT_W-1:0] reload
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         per    <= 1'b0;
         reload <= '0;
      end else if (wr_arm) begin
         en     <= wr_en_bit;
         per    <= wr_per_bit;
         reload <= wr_load;
      end else if (self_stop) begin
         en     <= 1'b0;
      end
   end
endmodule

// File: rtl/usec_down_cnt.sv
module usec_down_cnt #(
   parameter int unsigned CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             en,
   input  logic             per,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic at_zero;
   assign at_zero = (count == '0);
   assign expire  = tick & en & ~load & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (tick && en) begin
         if (at_zero) count <= per ? reload : '0;
         else         count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/usec_irq_flag.sv
module usec_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (ack) flag <= 1'b0;
   end
endmodule

// File: rtl/usec_timer.sv
module usec_timer
   import usec_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 29,
   parameter int unsigned EN_BIT    = 31,
   parameter int unsigned PER_BIT   = 30,
   parameter int unsigned FLAG_BIT  = 30,
   parameter bit          TICK_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic              reg_sel,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   output logic              irq
);
   if (CNT_W >= PER_BIT || CNT_W >= FLAG_BIT) begin : g_bad_width
      $error("usec_timer: count field overlaps control bits");
   end
   if (EN_BIT >= WORD_W || PER_BIT >= EN_BIT) begin : g_bad_bits
      $error("usec_timer: enable/periodic bit positions invalid");
   end

   logic             tick_w;
   logic             en_w;
   logic             per_w;
   logic [CNT_W-1:0] reload_w;
   logic [CNT_W-1:0] count_w;
   logic             expire_w;
   logic             flag_w;
   logic             wr_arm;
   logic             wr_ack;
   logic             wdata_unused;

   assign wr_arm       = reg_wr & (reg_sel_e'(reg_sel) == SEL_ARM);
   assign wr_ack       = reg_wr & (reg_sel_e'(reg_sel) == SEL_STAT) & reg_wdata[FLAG_BIT];
   assign wdata_unused = ^reg_wdata;

   usec_tick_cond #(.EDGE_MODE(TICK_EDGE)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_in  (us_tick),
      .tick_out (tick_w)
   );

   usec_arm_reg #(.CNT_W(CNT_W)) u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_arm     (wr_arm),
      .wr_en_bit  (reg_wdata[EN_BIT]),
      .wr_per_bit (reg_wdata[PER_BIT]),
      .wr_load    (reg_wdata[CNT_W-1:0]),
      .self_stop  (expire_w & ~per_w),
      .en         (en_w),
      .per        (per_w),
      .reload     (reload_w)
   );

   usec_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_arm),
      .load_val (reg_wdata[CNT_W-1:0]),
      .tick     (tick_w),
      .en       (en_w),
      .per      (per_w),
      .reload   (reload_w),
      .count    (count_w),
      .expire   (expire_w)
   );

   usec_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire_w),
      .ack   (wr_ack),
      .flag  (flag_w)
   );

   assign irq = flag_w;

   logic [WORD_W-1:0] arm_view;
   logic [WORD_W-1:0] stat_view;
   always_comb begin
      arm_view                = '0;
      arm_view[CNT_W-1:0]     = reload_w;
      arm_view[PER_BIT]       = per_w;
      arm_view[EN_BIT]        = en_w;
      stat_view               = '0;
      stat_view[CNT_W-1:0]    = count_w;
      stat_view[FLAG_BIT]     = flag_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rvalid <= 1'b0;
         reg_rdata  <= '0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) reg_rdata <= reg_sel ? stat_view : arm_view;
      end
   end
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
   parameter int unsigned CNT_W    = 29,
   parameter int unsigned FLAG_BIT = 30
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_sel,
   input logic [31:0]      reg_wdata,
   input logic             irq,
   input logic             tick,
   input logic             en,
   input logic             per,
   input logic [CNT_W-1:0] reload,
   input logic [CNT_W-1:0] count,
   input logic             expire
);
   logic ack;
   logic wr_arm;
   assign ack    = reg_wr & reg_sel & reg_wdata[FLAG_BIT];
   assign wr_arm = reg_wr & ~reg_sel;

   p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && en && (count != '0) && !wr_arm |=> count == CNT_W'($past(count) - 1'b1));
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !wr_arm |=> $stable(count));
   p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !per && !wr_arm |=> !en);
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire && per && !wr_arm |=> count == $past(reload));
   p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_arm && (reg_wdata == 32'd0) |=> !en && (count == '0));
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_arm |=> count == $past(reg_wdata[CNT_W-1:0]));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack |=> irq);
   p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !expire |=> !irq);
   p_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq);
endmodule

bind usec_timer usec_timer_chk #(.CNT_W(CNT_W), .FLAG_BIT(FLAG_BIT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .irq       (irq),
   .tick      (tick_w),
   .en        (en_w),
   .per       (per_w),
   .reload    (reload_w),
   .count     (count_w),
   .expire    (expire_w)
);

// File: tb/tb_usec_timer.sv
module tb_usec_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        us_tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rvalid;
   logic        irq;

   int total = 0;
   int bad   = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   usec_timer dut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
   );

   // monitor: compares read data against the scoreboard queue
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (reg_rvalid) begin
            total++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL %s: unexpected read act=%h exp=none", "R10", reg_rdata);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (reg_rdata !== e) begin
                  bad++;
                  $display("FAIL %s: read act=%h exp=%h", t, reg_rdata, e);
               end
            end
         end
      end
   end

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); us_tick = 1'b1;
         @(negedge clk); us_tick = 1'b0;
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [31:0] d, input logic with_tick);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; us_tick = with_tick;
      @(negedge clk);
      reg_wr = 1'b0; us_tick = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_exp(input logic sel, input logic [31:0] e, input string t);
      @(negedge clk);
      reg_rd = 1'b1; reg_sel = sel;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      reg_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string t);
      total++;
      if (irq !== e) begin
         bad++;
         $display("FAIL %s: irq act=%b exp=%b", t, irq, e);
      end
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_irq(1'b0, "R1");
      rd_exp(1'b0, 32'h0, "R1");
      rd_exp(1'b1, 32'h0, "R1");
      // R3 ticks while disarmed do nothing
      tick_n(3);
      chk_irq(1'b0, "R3");
      rd_exp(1'b1, 32'h0, "R3");
      // R2 bit 29 is not stored
      wr_reg(1'b0, 32'hA000_0007, 1'b0);
      rd_exp(1'b0, 32'h8000_0007, "R2");
      // one-shot with load 4: expiry on the fifth tick
      wr_reg(1'b0, 32'h8000_0004, 1'b0);
      rd_exp(1'b0, 32'h8000_0004, "R2");
      rd_exp(1'b1, 32'h0000_0004, "R10");
      tick_n(2);
      rd_exp(1'b1, 32'h0000_0002, "R3");
      tick_n(2);
      chk_irq(1'b0, "R3");
      tick_n(1);
      chk_irq(1'b1, "R3");
      rd_exp(1'b0, 32'h0000_0004, "R4");
      rd_exp(1'b1, 32'h4000_0000, "R10");
      tick_n(3);
      rd_exp(1'b1, 32'h4000_0000, "R4");
      // R8 acknowledge without bit 30 leaves irq set, with bit 30 clears it
      wr_reg(1'b1, 32'h0000_0000, 1'b0);
      chk_irq(1'b1, "R8");
      wr_reg(1'b1, 32'h4000_0000, 1'b0);
      chk_irq(1'b0, "R8");
      tick_n(4);
      chk_irq(1'b0, "R4");
      // R5 periodic load 2
      wr_reg(1'b0, 32'hC000_0002, 1'b0);
      tick_n(2);
      chk_irq(1'b0, "R5");
      tick_n(1);
      chk_irq(1'b1, "R5");
      rd_exp(1'b1, 32'h4000_0002, "R5");
      wr_reg(1'b1, 32'h4000_0000, 1'b0);
      tick_n(3);
      chk_irq(1'b1, "R5");
      wr_reg(1'b1, 32'h4000_0000, 1'b0);
      rd_exp(1'b1, 32'h0000_0002, "R5");
      // R9 acknowledge and expiry in one cycle, periodic load 0
      wr_reg(1'b0, 32'hC000_0000, 1'b0);
      tick_n(1);
      chk_irq(1'b1, "R9");
      wr_reg(1'b1, 32'h4000_0000, 1'b1);
      chk_irq(1'b1, "R9");
      wr_reg(1'b1, 32'h4000_0000, 1'b0);
      chk_irq(1'b0, "R9");
      // R7 rewrite reloads at once
      wr_reg(1'b0, 32'h8000_0005, 1'b0);
      tick_n(2);
      rd_exp(1'b1, 32'h0000_0003, "R7");
      wr_reg(1'b0, 32'h8000_0001, 1'b0);
      rd_exp(1'b1, 32'h0000_0001, "R7");
      tick_n(1);
      chk_irq(1'b0, "R7");
      tick_n(1);
      chk_irq(1'b1, "R7");
      wr_reg(1'b1, 32'h4000_0000, 1'b0);
      wr_reg(1'b0, 32'h8000_0003, 1'b1);
      rd_exp(1'b1, 32'h0000_0003, "R7");
      // R6 disarm
      wr_reg(1'b0, 32'h0000_0000, 1'b0);
      rd_exp(1'b0, 32'h0, "R6");
      rd_exp(1'b1, 32'h0, "R6");
      tick_n(5);
      chk_irq(1'b0, "R6");
      repeat (3) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R10: pending reads act=%0d exp=0", exp_q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule